// File: doc/BRIEF.md
# Shared Square-Root and Divide Engine

This block computes either an unsigned integer quotient or an unsigned integer square root with a single sequential datapath. A select input picks the operation when a start pulse is accepted. In divide mode the 32-bit operand is divided by a 16-bit divisor. In square-root mode the same 32-bit operand is the radicand. The root is found by Newton-Raphson steps, `x_next = (x + operand / x) >> 1`. Each step runs one pass of the shared shift-subtract divider, so no second arithmetic unit is needed.

The first root estimate is a power of two derived from the position of the operand's leading one. It always lies at or above the true root, so the estimates fall steadily. The loop stops when a new estimate is no smaller than the current one, and the current one is returned as the floor of the root. One divider pass takes 32 clock cycles plus one launch cycle. A root therefore costs a small number of such passes, and a quotient costs exactly one.

The controller has four states. IDLE waits for the first start after reset. LAUNCH fires one divider pass with the held operands. WAIT waits for that pass to finish. FINISH raises done and holds the result.

The transitions are as follows:
- IDLE or FINISH goes to LAUNCH on an accepted start that needs the divider.
- IDLE or FINISH goes to FINISH on an accepted start that has an immediate answer. These are a zero divisor and a zero radicand.
- LAUNCH goes to WAIT after one cycle.
- WAIT goes back to LAUNCH when a root step is still falling.
- WAIT goes to FINISH when a quotient is ready or when a root step has stopped falling.

Top module: `sqrt_div_unit`

## Requirements
- R1: After reset `done` is 0 and `result` is 0.
- R2: With `sel_sqrt` = 0, a start yields `result` = floor(`operand` / `divisor`) whenever that quotient is at most 0xFFFF.
- R3: With `sel_sqrt` = 0 and a quotient above 0xFFFF, `result` saturates to 0xFFFF.
- R4: With `sel_sqrt` = 0 and `divisor` = 0, `result` is 0xFFFF and `done` is high one cycle after the start.
- R5: With `sel_sqrt` = 1, a start yields `result` = floor(sqrt(`operand`)). The internal estimate never rises while the loop runs.
- R6: With `sel_sqrt` = 1 and `operand` = 0, `result` is 0 and `done` is high one cycle after the start.
- R7: A start while the unit is in LAUNCH or WAIT is ignored, and the running operation completes with its own operands and mode.
- R8: Once `done` is high, it stays high and `result` stays unchanged until the next start.
- R9: A start that needs the divider drops `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_sqrt | input | 1 | 1 = square root, 0 = divide; sampled with start |
| start | input | 1 | Begins an operation when the unit is in IDLE or FINISH |
| operand | input | 32 | Dividend or radicand, unsigned |
| divisor | input | 16 | Divisor, unsigned; unused for square root |
| done | output | 1 | Result valid, held until the next start |
| result | output | 16 | Quotient or integer square root |

## Verification
Two events can meet in one cycle: a new start and an operation that is still running. A second start, with different operands and the other mode, is pulsed in the middle of a divide. The bench then checks that the first operation's own answer comes out. Done and a new start also coincide. A start is issued while done is still high, and the bench judges that done drops the next cycle for a divider-based operation, or that the immediate answer appears at once for the zero cases.

// File: rtl/sqdv_pkg.sv
package sqdv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } sqdv_state_t;

endpackage

// File: rtl/sqdv_seed.sv
// Initial root estimate: 2^(floor(p/2)+1), where p is the leading-one index.
module sqdv_seed #(
    parameter int AW = 32,
    parameter int XW = 17
) (
    input  logic [AW-1:0] value,
    output logic [XW-1:0] seed
);
    localparam int PW = $clog2(AW) + 1;

    logic [PW-1:0] lead_pos;
    logic [PW-1:0] shamt;

    always_comb begin
        lead_pos = '0;
        for (int i = 0; i < AW; i++) begin
            if (value[i]) lead_pos = PW'(i);
        end
        shamt = (lead_pos >> 1) + PW'(1);
        seed  = XW'(1) << shamt;
    end

endmodule

// File: rtl/sqdv_divider.sv
// Restoring shift-subtract divider producing one quotient bit per cycle.
module sqdv_divider #(
    parameter int NW = 32,
    parameter int DW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] numer,
    input  logic [DW-1:0] denom,
    output logic          fin,
    output logic [NW-1:0] quot
);
    localparam int RW = DW + 1;
    localparam int CW = $clog2(NW + 1);

    logic [RW-1:0] rem_q;
    logic [NW-1:0] quo_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          fin_q;
    logic [RW-1:0] shifted;
    logic [RW:0]   trial;

    always_comb begin
        shifted = {rem_q[RW-2:0], quo_q[NW-1]};
        trial   = {1'b0, shifted} - {2'b00, denom};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            quo_q <= numer;
            cnt_q <= CW'(NW);
            run_q <= 1'b1;
            fin_q <= 1'b0;
        end else if (run_q) begin
            if (trial[RW]) begin
                rem_q <= shifted;
                quo_q <= {quo_q[NW-2:0], 1'b0};
            end else begin
                rem_q <= trial[RW-1:0];
                quo_q <= {quo_q[NW-2:0], 1'b1};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign fin  = fin_q;
    assign quot = quo_q;

    assert_fin_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    assert_go_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !fin);

endmodule

// File: rtl/sqrt_div_unit.sv
module sqrt_div_unit #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_sqrt,
    input  logic          start,
    input  logic [AW-1:0] operand,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] result
);
    import sqdv_pkg::*;

    localparam int XW = DW + 1;

    sqdv_state_t   state, state_nxt;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic          mode_q;
    logic [XW-1:0] x_q;
    logic [DW-1:0] res_q;

    logic          accept;
    logic          quick;
    logic          div_go;
    logic          div_fin;
    logic [AW-1:0] div_quot;
    logic [XW-1:0] div_den;
    logic [XW-1:0] seed;
    logic [AW:0]   step_sum;
    logic [AW-1:0] x_new;
    logic          stop;
    logic          quot_big;

    sqdv_seed #(.AW(AW), .XW(XW)) u_seed (
        .value (operand),
        .seed  (seed)
    );

    sqdv_divider #(.NW(AW), .DW(XW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .numer (a_q),
        .denom (div_den),
        .fin   (div_fin),
        .quot  (div_quot)
    );

    always_comb begin
        accept   = start && (state == ST_IDLE || state == ST_FINISH);
        quick    = sel_sqrt ? (operand == '0) : (divisor == '0);
        div_den  = mode_q ? x_q : {1'b0, d_q};
        step_sum = {1'b0, AW'(x_q)} + {1'b0, div_quot};
        x_new    = step_sum[AW:1];
        stop     = x_new >= AW'(x_q);
        quot_big = |div_quot[AW-1:DW];
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_FINISH: begin
                if (accept) state_nxt = quick ? ST_FINISH : ST_LAUNCH;
            end
            ST_LAUNCH: state_nxt = ST_WAIT;
            ST_WAIT: begin
                if (div_fin) state_nxt = (mode_q && !stop) ? ST_LAUNCH : ST_FINISH;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            d_q    <= '0;
            mode_q <= 1'b0;
            x_q    <= '0;
            res_q  <= '0;
        end else if (accept) begin
            a_q    <= operand;
            d_q    <= divisor;
            mode_q <= sel_sqrt;
            x_q    <= seed;
            if (sel_sqrt && operand == '0)       res_q <= '0;
            else if (!sel_sqrt && divisor == '0) res_q <= '1;
        end else if (state == ST_WAIT && div_fin) begin
            if (mode_q) begin
                if (stop) res_q <= x_q[DW-1:0];
                else      x_q   <= x_new[XW-1:0];
            end else begin
                res_q <= quot_big ? '1 : div_quot[DW-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        div_go = (state == ST_LAUNCH);
        done   = (state == ST_FINISH);
        result = res_q;
    end

    assert_quot_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && div_fin && !mode_q && !quot_big) |=> (done && result == $past(div_quot[DW-1:0])));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && div_fin && !mode_q && quot_big) |=> (done && result == '1));
    assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sel_sqrt && divisor == '0) |=> (done && result == '1));
    assert_est_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (x_q <= $past(x_q)));
    assert_root_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_sqrt && operand == '0) |=> (done && result == '0));
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAUNCH || state == ST_WAIT) |=> ($stable(a_q) && $stable(d_q) && $stable(mode_q)));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));
    assert_done_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !quick) |=> !done);

endmodule

// File: tb/test_sqrt_div_unit.sv
module test_sqrt_div_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_sqrt = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [15:0] divisor = '0;
    logic        done;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    sqrt_div_unit i_sqrt_div_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_sqrt (sel_sqrt),
        .start    (start),
        .operand  (operand),
        .divisor  (divisor),
        .done     (done),
        .result   (result)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] ref_isqrt(input logic [31:0] v);
        logic [15:0] r = '0;
        for (int b = 15; b >= 0; b--) begin
            logic [15:0] t = r | (16'd1 << b);
            if ({16'd0, t} * {16'd0, t} <= {32'd0, v}) r = t;
        end
        return r;
    endfunction

    function automatic logic [15:0] ref_div(input logic [31:0] a, input logic [15:0] d);
        logic [31:0] q;
        if (d == 0) return 16'hFFFF;
        q = a / {16'd0, d};
        return (q > 32'hFFFF) ? 16'hFFFF : q[15:0];
    endfunction

    task automatic pulse(input logic m, input logic [31:0] a, input logic [15:0] d);
        @(negedge clk);
        sel_sqrt = m; operand = a; divisor = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " done seen"}, {31'd0, done}, 32'd1);
    endtask

    task automatic run_case(input string tag, input logic m, input logic [31:0] a, input logic [15:0] d);
        logic [15:0] exp;
        exp = m ? ref_isqrt(a) : ref_div(a, d);
        pulse(m, a, d);
        wait_done(tag);
        check(tag, {16'd0, result}, {16'd0, exp});
    endtask

    task automatic test_reset_R1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 result after reset", {16'd0, result}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_divide_R2;
        run_case("R2 100/7", 1'b0, 32'd100, 16'd7);
        run_case("R2 12345678/1000", 1'b0, 32'd12345678, 16'd1000);
        run_case("R2 0xFFFEFFFF/0xFFFF", 1'b0, 32'hFFFE_FFFF, 16'hFFFF);
        run_case("R2 5/9", 1'b0, 32'd5, 16'd9);
    endtask

    task automatic test_saturate_R3;
        run_case("R3 0xFFFF0000/0xFFFF", 1'b0, 32'hFFFF_0000, 16'hFFFF);
        run_case("R3 0xFFFFFFFF/1", 1'b0, 32'hFFFF_FFFF, 16'd1);
    endtask

    task automatic test_zero_div_R4;
        pulse(1'b0, 32'd77, 16'd0);
        check("R4 done next cycle", {31'd0, done}, 32'd1);
        check("R4 zero divisor result", {16'd0, result}, 32'h0000_FFFF);
    endtask

    task automatic test_sqrt_R5;
        run_case("R5 sqrt 1", 1'b1, 32'd1, 16'd0);
        run_case("R5 sqrt 2", 1'b1, 32'd2, 16'd0);
        run_case("R5 sqrt 15", 1'b1, 32'd15, 16'd0);
        run_case("R5 sqrt 16", 1'b1, 32'd16, 16'd0);
        run_case("R5 sqrt 1e9", 1'b1, 32'd1000000000, 16'd0);
        run_case("R5 sqrt 2^30", 1'b1, 32'h4000_0000, 16'd0);
        run_case("R5 sqrt max", 1'b1, 32'hFFFF_FFFF, 16'd0);
        run_case("R5 sqrt 65535^2-1", 1'b1, 32'hFFFE_0000, 16'd0);
    endtask

    task automatic test_sqrt_zero_R6;
        pulse(1'b1, 32'd0, 16'd5);
        check("R6 done next cycle", {31'd0, done}, 32'd1);
        check("R6 zero radicand result", {16'd0, result}, 32'd0);
    endtask

    task automatic test_busy_R7;
        pulse(1'b0, 32'd1000, 16'd3);
        repeat (5) @(negedge clk);
        pulse(1'b1, 32'hFFFF_FFFF, 16'd0);
        repeat (3) @(negedge clk);
        pulse(1'b0, 32'd9, 16'd0);
        check("R7 still busy", {31'd0, done}, 32'd0);
        wait_done("R7");
        check("R7 first operation kept", {16'd0, result}, 32'd333);
    endtask

    task automatic test_hold_R8_R9;
        run_case("R8 setup 4000/4", 1'b0, 32'd4000, 16'd4);
        repeat (25) @(negedge clk);
        check("R8 done held", {31'd0, done}, 32'd1);
        check("R8 result held", {16'd0, result}, 32'd1000);
        pulse(1'b1, 32'd81, 16'd0);
        check("R9 done drops", {31'd0, done}, 32'd0);
        wait_done("R9");
        check("R9 new root", {16'd0, result}, 32'd9);
    endtask

    initial begin
        test_reset_R1();
        test_divide_R2();
        test_saturate_R3();
        test_zero_div_R4();
        test_sqrt_R5();
        test_sqrt_zero_R6();
        test_busy_R7();
        test_hold_R8_R9();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule